// File: doc/BRIEF.md
# Cascaded Two-Digit Programmable Down-Counter

This block divides its clock by a value programmed as two digits. Each digit is a small down-counter. Each one picks its own wrap rule: binary, where the digit runs through all sixteen codes, or decimal, where it runs through ten. The low digit steps on every enabled clock. The high digit steps only when the low digit is at zero. When both digits reach zero, the pair reloads from its presets on the next enabled clock and raises a one-clock terminal pulse.

The zero test is decoded in parallel from the digit registers, so the reload happens on the same edge that leaves the zero state. No cycle is lost. The cascade output shows, in the same cycle, that this pair is about to roll over. It can drive the enable of a further divider stage, so wider dividers can be chained. A synchronous load restarts the count from the presets at any time.

Top module: `cdiv_top`

## Requirements
- R1: A synchronous reset clears both digits to zero and drives `tc_o` low. With `cnt_en_i` high after reset, `cascade_o` is high at once and `tc_o` is high after the first clock.
- R2: `preset_i[3:0]` is the low digit and `preset_i[7:4]` the high digit. `bcd_i[0]` selects decimal (1) or binary (0) wrap for the low digit, and `bcd_i[1]` does the same for the high digit. With `cnt_en_i` held high, `tc_o` pulses once every `hi*M + lo + 1` clocks, where M is 10 when the low digit is decimal and 16 when it is binary.
- R3: On an enabled clock where the low digit is zero and the high digit is not, the low digit wraps to 9 in decimal mode and to 15 in binary mode.
- R4: The high digit changes only on an enabled clock where the low digit is zero. With `cnt_en_i` low and no load, the count holds, `tc_o` stays low and `cascade_o` stays low.
- R5: A preset digit of 10 to 15 on a decimal-mode digit is loaded as 9. A binary-mode digit loads its preset unchanged.
- R6: A high `load_i` reloads both digits from the presets on the next clock and takes priority over counting. During such a clock `cascade_o` is low, and the load produces no `tc_o` pulse.
- R7: `tc_o` is a registered pulse that is high for the clock after each rollover edge. When both presets are zero, it stays high on every enabled clock.
- R8: `cascade_o` is high in the same cycle exactly when `cnt_en_i` is high, `load_i` is low and both digits are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en_i | input | 1 | Cascade enable in; counting happens only when high |
| load_i | input | 1 | Synchronous reload from the presets |
| preset_i | input | 8 | Preset digits, low digit in bits 3:0 |
| bcd_i | input | 2 | Per-digit wrap mode, 1 = decimal |
| cascade_o | output | 1 | Same-cycle rollover indication for a following stage |
| tc_o | output | 1 | Registered terminal-count pulse |

## Verification
A digit holding a wrong value shows up as a wrong spacing between `tc_o` pulses. A wrong wrap value in the low digit changes the period by a multiple of six clocks, and a bad clamp changes it by whole low-digit cycles. Both become visible at the second pulse, within about 240 clocks at the largest presets. A wrong zero decode shows up sooner: `cascade_o` goes high in a cycle where the pair is not at zero, or stays low when it is. A `tc_o` that does not follow `cascade_o` by one clock shows up on the first rollover.

// File: rtl/cdiv_pkg.sv
package cdiv_pkg;

  localparam int CDIV_DEC_TOP = 9;

  typedef struct packed {
    logic reload;
    logic step;
  } cdiv_ctl_t;

endpackage

// File: rtl/cdiv_digit.sv
module cdiv_digit
  import cdiv_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  cdiv_ctl_t    ctl,
  input  logic         dec_mode,
  input  logic [W-1:0] preset,
  output logic [W-1:0] q,
  output logic         is_zero
);

  localparam logic [W-1:0] BIN_TOP = {W{1'b1}};
  localparam logic [W-1:0] DEC_TOP = W'(CDIV_DEC_TOP);

  logic [W-1:0] wrap_val;
  logic [W-1:0] load_val;

  assign wrap_val = dec_mode ? DEC_TOP : BIN_TOP;
  assign load_val = (dec_mode && (preset > DEC_TOP)) ? DEC_TOP : preset;
  assign is_zero  = (q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (ctl.reload) begin
      q <= load_val;
    end else if (ctl.step) begin
      q <= is_zero ? wrap_val : (q - W'(1));
    end
  end

endmodule

// File: rtl/cdiv_zero_tree.sv
module cdiv_zero_tree #(
  parameter int NDIG = 2
) (
  input  logic [NDIG-1:0] zero_in,
  output logic [NDIG-1:0] below_zero,
  output logic            all_zero
);

  for (genvar i = 0; i < NDIG; i++) begin : g_pref
    if (i == 0) begin : g_first
      assign below_zero[i] = 1'b1;
    end else begin : g_rest
      assign below_zero[i] = &zero_in[i-1:0];
    end
  end

  assign all_zero = &zero_in;

endmodule

// File: rtl/cdiv_top.sv
module cdiv_top
  import cdiv_pkg::*;
#(
  parameter int W    = 4,
  parameter int NDIG = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cnt_en_i,
  input  logic              load_i,
  input  logic [NDIG*W-1:0] preset_i,
  input  logic [NDIG-1:0]   bcd_i,
  output logic              cascade_o,
  output logic              tc_o
);

  localparam int TOTAL_W = NDIG * W;

  logic [TOTAL_W-1:0] count_q;
  logic [NDIG-1:0]    digit_zero;
  logic [NDIG-1:0]    below_zero;
  logic               all_zero;
  logic               rollover;
  logic               tc_q;
  cdiv_ctl_t          ctl [NDIG];

  cdiv_zero_tree #(.NDIG(NDIG)) u_zero (
    .zero_in    (digit_zero),
    .below_zero (below_zero),
    .all_zero   (all_zero)
  );

  assign rollover = cnt_en_i & all_zero & ~load_i;

  for (genvar d = 0; d < NDIG; d++) begin : g_digit
    assign ctl[d].reload = load_i | rollover;
    assign ctl[d].step   = cnt_en_i & below_zero[d] & ~all_zero & ~load_i;

    cdiv_digit #(.W(W)) u_digit (
      .clk      (clk),
      .rst      (rst),
      .ctl      (ctl[d]),
      .dec_mode (bcd_i[d]),
      .preset   (preset_i[d*W +: W]),
      .q        (count_q[d*W +: W]),
      .is_zero  (digit_zero[d])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tc_q <= 1'b0;
    end else begin
      tc_q <= rollover;
    end
  end

  assign cascade_o = rollover;
  assign tc_o      = tc_q;

endmodule

// File: rtl/cdiv_top_chk.sv
module cdiv_top_chk #(
  parameter int W    = 4,
  parameter int NDIG = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              cnt_en_i,
  input logic              load_i,
  input logic [NDIG-1:0]   bcd_i,
  input logic              cascade_o,
  input logic              tc_o,
  input logic [NDIG*W-1:0] count
);

  AST_TC_AFTER_ROLL: assert property (@(posedge clk) disable iff (rst) cascade_o |=> tc_o); // R7
  AST_NO_TC_IDLE: assert property (@(posedge clk) disable iff (rst) !cascade_o |=> !tc_o); // R6
  AST_CASCADE_EN: assert property (@(posedge clk) disable iff (rst) cascade_o |-> (cnt_en_i && !load_i)); // R8
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst) (!cnt_en_i && !load_i) |=> $stable(count)); // R4
  AST_HIGH_WAITS: assert property (@(posedge clk) disable iff (rst) (!load_i && count[W-1:0] != '0) |=> $stable(count[NDIG*W-1:W])); // R4
  AST_LOW_WRAP: assert property (@(posedge clk) disable iff (rst) (cnt_en_i && !load_i && count[W-1:0] == '0 && count != '0) |=> (count[W-1:0] == ($past(bcd_i[0]) ? W'(9) : {W{1'b1}}))); // R3

  for (genvar g = 0; g < NDIG; g++) begin : g_rng
    AST_DEC_CLAMP: assert property (@(posedge clk) disable iff (rst) (load_i && bcd_i[g]) |=> (count[g*W +: W] <= W'(9))); // R5
  end

endmodule

bind cdiv_top cdiv_top_chk #(.W(W), .NDIG(NDIG)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cnt_en_i  (cnt_en_i),
  .load_i    (load_i),
  .bcd_i     (bcd_i),
  .cascade_o (cascade_o),
  .tc_o      (tc_o),
  .count     (count_q)
);

// File: tb/tb_cdiv_top.sv
`timescale 1ns/1ps
module tb_cdiv_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cnt_en_i = 1'b0;
  logic       load_i = 1'b0;
  logic [7:0] preset_i = '0;
  logic [1:0] bcd_i = '0;
  logic       cascade_o;
  logic       tc_o;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  cdiv_top dut (
    .clk       (clk),
    .rst       (rst),
    .cnt_en_i  (cnt_en_i),
    .load_i    (load_i),
    .preset_i  (preset_i),
    .bcd_i     (bcd_i),
    .cascade_o (cascade_o),
    .tc_o      (tc_o)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_load(input logic [3:0] hi, input logic [3:0] lo, input logic [1:0] mode);
    preset_i = {hi, lo};
    bcd_i    = mode;
    load_i   = 1'b1;
    step();
    load_i   = 1'b0;
  endtask

  task automatic edges_to_tc(output int n);
    n = 0;
    do begin
      step();
      n++;
    end while (!tc_o && n < 400);
  endtask

  task automatic period_test(input string req, input logic [3:0] hi, input logic [3:0] lo,
                             input logic [1:0] mode, input int exp);
    int n;
    cnt_en_i = 1'b0;
    do_load(hi, lo, mode);
    cnt_en_i = 1'b1;
    edges_to_tc(n);
    check({req, " first period"}, n, exp);
    edges_to_tc(n);
    check({req, " second period"}, n, exp);
    if (exp > 1) begin
      step();
      check("R7 pulse one cycle", int'(tc_o), 0);
    end
    cnt_en_i = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    cnt_en_i = 1'b0;
    step(); step();
    rst = 1'b0;
    check("R1 tc low after reset", int'(tc_o), 0);
    cnt_en_i = 1'b1;
    #1;
    check("R1 cascade at zero state", int'(cascade_o), 1);
    step();
    check("R1 first enabled clock gives tc", int'(tc_o), 1);
    cnt_en_i = 1'b0;
    step();
  endtask

  task automatic t_modes();
    period_test("R2 binary/binary", 4'd2, 4'd5, 2'b00, 2*16 + 5 + 1);
    period_test("R2 decimal/decimal", 4'd3, 4'd7, 2'b11, 3*10 + 7 + 1);
    period_test("R3 low decimal high binary", 4'd12, 4'd4, 2'b01, 12*10 + 4 + 1);
    period_test("R3 low binary high decimal", 4'd9, 4'd15, 2'b10, 9*16 + 15 + 1);
  endtask

  task automatic t_clamp();
    period_test("R5 decimal clamp both", 4'd14, 4'd12, 2'b11, 9*10 + 9 + 1);
    period_test("R5 binary no clamp", 4'd14, 4'd12, 2'b00, 14*16 + 12 + 1);
    period_test("R5 low clamp only", 4'd1, 4'd12, 2'b01, 1*10 + 9 + 1);
  endtask

  task automatic t_enable_gate();
    int n;
    cnt_en_i = 1'b0;
    do_load(4'd0, 4'd3, 2'b00);
    cnt_en_i = 1'b1;
    step(); step();
    cnt_en_i = 1'b0;
    for (int i = 0; i < 5; i++) begin
      step();
      check("R4 no tc while disabled", int'(tc_o), 0);
      check("R4 no cascade while disabled", int'(cascade_o), 0);
    end
    cnt_en_i = 1'b1;
    edges_to_tc(n);
    check("R4 count held across gap", n, 2);
    cnt_en_i = 1'b0;
  endtask

  task automatic t_load();
    int n;
    cnt_en_i = 1'b0;
    do_load(4'd1, 4'd0, 2'b00);
    cnt_en_i = 1'b1;
    for (int i = 0; i < 5; i++) step();
    do_load(4'd0, 4'd2, 2'b00);
    edges_to_tc(n);
    check("R6 reload restarts count", n, 3);
    cnt_en_i = 1'b0;
    do_load(4'd0, 4'd0, 2'b00);
    check("R6 load edge gives no tc", int'(tc_o), 0);
    load_i = 1'b1;
    cnt_en_i = 1'b1;
    #1;
    check("R8 cascade low during load", int'(cascade_o), 0);
    step();
    check("R6 no tc from load at zero", int'(tc_o), 0);
    load_i = 1'b0;
    #1;
    check("R8 cascade high at zero", int'(cascade_o), 1);
    step();
    check("R7 zero preset tc", int'(tc_o), 1);
    step();
    check("R7 zero preset tc stays", int'(tc_o), 1);
    cnt_en_i = 1'b0;
    #1;
    check("R8 cascade follows enable", int'(cascade_o), 0);
    step();
    check("R7 tc drops when disabled", int'(tc_o), 0);
  endtask

  task automatic t_cascade_nonzero();
    cnt_en_i = 1'b0;
    do_load(4'd0, 4'd1, 2'b00);
    cnt_en_i = 1'b1;
    #1;
    check("R8 no cascade at nonzero", int'(cascade_o), 0);
    step();
    check("R8 cascade once zero", int'(cascade_o), 1);
    cnt_en_i = 1'b0;
    step();
  endtask

  initial begin
    #2000000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_modes();
    t_clamp();
    t_enable_gate();
    t_load();
    t_cascade_nonzero();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule